// File: doc/BRIEF.md
# Interrupt Destination and Delivery Decoder

This block turns one interrupt request into a per-target delivery mask for a set of local interrupt controllers. The default set has 32 targets. A request arrives in one of two forms. The first is a message-signalled write, given as an address word and a data word. The second is a command-register write: a command word, a separate destination byte and the index of the sending target. The command word may carry a destination shorthand that overrides the destination byte.

The block keeps a small table with one entry per target. Each entry holds the target's 8-bit physical ID, its 8-bit logical ID and a 4-bit model field. The model field selects flat or cluster logical matching.

A request is accepted when valid and ready are both high. In the next cycle the block presents, with one of three strobes:
- the registered mask,
- the vector,
- the delivery mode,
- the trigger bit.

The three strobes are:
- a delivery strobe for a normal interrupt;
- an arbitration-resync strobe for an INIT command that deasserts the level, which tells each selected target to reload its arbitration ID from its own ID;
- a no-target flag when nothing matched.

Top module: `intdest_decoder`

## Requirements
- R1: For a message request, the destination is address bits 19:12 and logical mode is address bit 2. The vector is data bits 7:0, the delivery mode is data bits 10:8 and the trigger is data bit 15. The arbitration-resync rule of R8 does not apply to message requests.
- R2: For a command request, the command word gives:
  - vector in bits 7:0;
  - delivery mode in bits 10:8;
  - logical mode in bit 11;
  - level in bit 14;
  - trigger in bit 15;
  - shorthand in bits 19:18.

  The destination byte comes from `cmd_dest`.
- R3: In physical mode, destination 0xFF selects every target. Any other value selects only the lowest-indexed target whose physical ID equals the destination. If no target's physical ID matches, nothing is selected.
- R4: In logical mode, a target with model 0xF (flat) matches when the destination AND its logical ID is nonzero.
- R5: In logical mode, a target with model 0x0 (cluster) matches when two conditions both hold: the upper nibbles of destination and logical ID are equal, and the AND of their lower nibbles is nonzero. A target with any other model value never matches in logical mode.
- R6: The command shorthand works as follows:
  - 0 uses the destination;
  - 1 selects only the sender `cmd_src`;
  - 2 selects every target;
  - 3 selects every target except the sender.
- R7: Delivery mode 1 (lowest priority) keeps only the lowest-indexed bit of the selected mask.
- R8: A command with delivery mode 5, level 0 and trigger 1 and a non-empty mask raises `arb_sync` with the mask. It does not raise `dlv_valid`. Any other combination delivers normally.
- R9: An empty final mask raises `no_target` with `dlv_mask` zero, and neither `dlv_valid` nor `arb_sync` is raised.
- R10: Exactly one of `dlv_valid`, `arb_sync` and `no_target` pulses, in the cycle after acceptance. `req_ready` is low in that same cycle and high again in the cycle after it. No strobe appears without an accepted request.
- R11: After reset, `req_ready` is high and no strobe is raised. Each table entry holds physical ID equal to its index, logical ID 0 and model 0xF.
- R12: A table write through `cfg_we` replaces the entry at `cfg_idx`, and requests accepted after it use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_phys_id | input | 8 | New physical ID |
| cfg_log_id | input | 8 | New logical ID |
| cfg_model | input | 4 | New model field (0xF flat, 0x0 cluster) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_is_cmd | input | 1 | 1: command request, 0: message request |
| msg_addr | input | 32 | Message address word |
| msg_data | input | 32 | Message data word |
| cmd_word | input | 32 | Command word |
| cmd_dest | input | 8 | Command destination byte |
| cmd_src | input | IDX_W | Index of the sending target |
| dlv_valid | output | 1 | Delivery strobe |
| arb_sync | output | 1 | Arbitration-ID reload strobe |
| no_target | output | 1 | Empty-mask flag |
| dlv_mask | output | N_TGT | Registered target mask |
| dlv_vector | output | 8 | Registered vector |
| dlv_mode | output | 3 | Registered delivery mode |
| dlv_trig | output | 1 | Registered trigger bit |

## Verification
The assertions assume three things about the inputs:
- `cmd_src` and `cfg_idx` always name an existing target;
- a table write is not issued in the same cycle as a request it is meant to affect;
- requests are only offered under the valid/ready handshake, so a held request is never counted twice.

The bench keeps to these assumptions as follows. It sweeps source indices only over the configured eight targets. It performs table writes while `req_valid` is low. It drops `req_valid` in the cycle after each acceptance.

// File: rtl/idd_pkg.sv
package idd_pkg;

  localparam int ID_W = 8;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWEST  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSVD    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXTINT  = 3'd7
  } dmode_e;

  typedef struct packed {
    logic [ID_W-1:0] dest;
    logic            logical;
    logic [7:0]      vector;
    dmode_e          mode;
    logic            level;
    logic            trig;
    logic [1:0]      shorthand;
  } req_fields_t;

endpackage

// File: rtl/idd_field_decode.sv
module idd_field_decode
  import idd_pkg::*;
(
  input  logic        is_cmd,
  input  logic [31:0] addr,
  input  logic [31:0] data,
  input  logic [31:0] cmd_word,
  input  logic [7:0]  cmd_dest,
  output req_fields_t f
);

  // R1 message fields, R2 command fields
  always_comb begin
    if (is_cmd) begin
      f.dest      = cmd_dest;
      f.logical   = cmd_word[11];
      f.vector    = cmd_word[7:0];
      f.mode      = dmode_e'(cmd_word[10:8]);
      f.level     = cmd_word[14];
      f.trig      = cmd_word[15];
      f.shorthand = cmd_word[19:18];
    end else begin
      f.dest      = addr[19:12];
      f.logical   = addr[2];
      f.vector    = data[7:0];
      f.mode      = dmode_e'(data[10:8]);
      f.level     = data[14];
      f.trig      = data[15];
      f.shorthand = 2'd0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr[31:20], addr[11:3], addr[1:0], data[31:16],
                         data[13:11], cmd_word[31:20], cmd_word[17:16],
                         cmd_word[13:12]};

endmodule

// File: rtl/idd_first_set.sv
module idd_first_set #(
  parameter int N = 32
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] first
);

  // isolate lowest set bit: two's complement trick, one carry chain
  assign first = vec & (~vec + N'(1));

endmodule

// File: rtl/idd_target_table.sv
module idd_target_table #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IDX_W-1:0]     idx,
  input  logic [7:0]           phys_in,
  input  logic [7:0]           log_in,
  input  logic [3:0]           model_in,
  output logic [N-1:0][7:0]    phys_q,
  output logic [N-1:0][7:0]    log_q,
  output logic [N-1:0][3:0]    model_q
);

  // R11 defaults, R12 writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        phys_q[i]  <= 8'(i);
        log_q[i]   <= 8'h00;
        model_q[i] <= 4'hF;
      end
    end else if (we) begin
      phys_q[idx]  <= phys_in;
      log_q[idx]   <= log_in;
      model_q[idx] <= model_in;
    end
  end

endmodule

// File: rtl/idd_target_match.sv
module idd_target_match #(
  parameter int N = 32
) (
  input  logic [7:0]        dest,
  input  logic              logical,
  input  logic [N-1:0][7:0] phys,
  input  logic [N-1:0][7:0] lid,
  input  logic [N-1:0][3:0] model,
  output logic [N-1:0]      hit
);

  localparam logic [7:0] BCAST = 8'hFF;
  localparam logic [3:0] MDL_FLAT = 4'hF;
  localparam logic [3:0] MDL_CLUS = 4'h0;

  logic [N-1:0] phys_eq;
  logic [N-1:0] phys_one;
  logic [N-1:0] log_hit;

  for (genvar t = 0; t < N; t++) begin : g_tgt
    logic flat_m, clus_m;
    assign phys_eq[t] = (phys[t] == dest);
    // R4 flat compare
    assign flat_m = (model[t] == MDL_FLAT) && ((dest & lid[t]) != 8'h00);
    // R5 cluster compare
    assign clus_m = (model[t] == MDL_CLUS) && (dest[7:4] == lid[t][7:4]) &&
                    ((dest[3:0] & lid[t][3:0]) != 4'h0);
    assign log_hit[t] = flat_m | clus_m;
  end

  idd_first_set #(.N(N)) u_phys_first (.vec(phys_eq), .first(phys_one));

  // R3 physical: broadcast or first matching ID
  always_comb begin
    if (logical)            hit = log_hit;
    else if (dest == BCAST) hit = '1;
    else                    hit = phys_one;
  end

  // p_phys_single_r3: a non-broadcast physical request reaches at most one target
  always_comb begin
    if (!logical && dest != BCAST)
      p_phys_single_r3: assert ($onehot0(hit));
  end

endmodule

// File: rtl/intdest_decoder.sv
module intdest_decoder
  import idd_pkg::*;
#(
  parameter int N_TGT = 32,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [7:0]       cfg_phys_id,
  input  logic [7:0]       cfg_log_id,
  input  logic [3:0]       cfg_model,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_cmd,
  input  logic [31:0]      msg_addr,
  input  logic [31:0]      msg_data,
  input  logic [31:0]      cmd_word,
  input  logic [7:0]       cmd_dest,
  input  logic [IDX_W-1:0] cmd_src,
  output logic             dlv_valid,
  output logic             arb_sync,
  output logic             no_target,
  output logic [N_TGT-1:0] dlv_mask,
  output logic [7:0]       dlv_vector,
  output logic [2:0]       dlv_mode,
  output logic             dlv_trig
);

  req_fields_t              f;
  logic [N_TGT-1:0][7:0]    phys_q;
  logic [N_TGT-1:0][7:0]    log_q;
  logic [N_TGT-1:0][3:0]    model_q;
  logic [N_TGT-1:0]         hit;
  logic [N_TGT-1:0]         sender;
  logic [N_TGT-1:0]         sh_mask;
  logic [N_TGT-1:0]         lowest;
  logic [N_TGT-1:0]         final_mask;
  logic                     arb_req;
  logic                     accept;
  logic                     busy;

  idd_field_decode u_dec (
    .is_cmd   (req_is_cmd),
    .addr     (msg_addr),
    .data     (msg_data),
    .cmd_word (cmd_word),
    .cmd_dest (cmd_dest),
    .f        (f)
  );

  idd_target_table #(.N(N_TGT), .IDX_W(IDX_W)) u_tab (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .idx      (cfg_idx),
    .phys_in  (cfg_phys_id),
    .log_in   (cfg_log_id),
    .model_in (cfg_model),
    .phys_q   (phys_q),
    .log_q    (log_q),
    .model_q  (model_q)
  );

  idd_target_match #(.N(N_TGT)) u_match (
    .dest    (f.dest),
    .logical (f.logical),
    .phys    (phys_q),
    .lid     (log_q),
    .model   (model_q),
    .hit     (hit)
  );

  // R6 shorthand
  assign sender = N_TGT'(1) << cmd_src;
  always_comb begin
    case (f.shorthand)
      2'd1:    sh_mask = sender;
      2'd2:    sh_mask = '1;
      2'd3:    sh_mask = ~sender;
      default: sh_mask = hit;
    endcase
  end

  // R7 lowest priority: single target
  idd_first_set #(.N(N_TGT)) u_low (.vec(sh_mask), .first(lowest));
  assign final_mask = (f.mode == DM_LOWEST) ? lowest : sh_mask;

  // R8 INIT level-deassert becomes an arbitration resync
  assign arb_req = req_is_cmd && (f.mode == DM_INIT) && !f.level && f.trig;

  // R10 handshake: one request in flight
  assign accept    = req_valid && req_ready;
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      dlv_valid  <= 1'b0;
      arb_sync   <= 1'b0;
      no_target  <= 1'b0;
      dlv_mask   <= '0;
      dlv_vector <= 8'h00;
      dlv_mode   <= 3'd0;
      dlv_trig   <= 1'b0;
    end else begin
      busy      <= accept;
      dlv_valid <= accept && (|final_mask) && !arb_req;
      arb_sync  <= accept && (|final_mask) && arb_req;
      no_target <= accept && !(|final_mask);
      if (accept) begin
        dlv_mask   <= final_mask;
        dlv_vector <= f.vector;
        dlv_mode   <= f.mode;
        dlv_trig   <= f.trig;
      end
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dlv_valid, arb_sync, no_target}));

  p_resp_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> (dlv_valid || arb_sync || no_target));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !(dlv_valid || arb_sync || no_target));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  p_lowest_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_mode == DM_LOWEST) |-> $onehot(dlv_mask));

  p_empty_mask_r9: assert property (@(posedge clk) disable iff (rst)
    no_target |-> (dlv_mask == '0));

  p_nonempty_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid || arb_sync) |-> (dlv_mask != '0));

  p_resync_init_r8: assert property (@(posedge clk) disable iff (rst)
    arb_sync |-> (dlv_mode == DM_INIT));

endmodule

// File: tb/intdest_decoder_bench.sv
module intdest_decoder_bench;

  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0]    cfg_phys_id = '0;
  logic [7:0]    cfg_log_id = '0;
  logic [3:0]    cfg_model = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_is_cmd = 1'b0;
  logic [31:0]   msg_addr = '0;
  logic [31:0]   msg_data = '0;
  logic [31:0]   cmd_word = '0;
  logic [7:0]    cmd_dest = '0;
  logic [IW-1:0] cmd_src = '0;
  logic          dlv_valid, arb_sync, no_target, dlv_trig;
  logic [N-1:0]  dlv_mask;
  logic [7:0]    dlv_vector;
  logic [2:0]    dlv_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] b_phys [N];
  logic [7:0] b_log [N];
  logic [3:0] b_model [N];

  always #5 clk = ~clk;

  intdest_decoder #(.N_TGT(N)) u_intdest_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_phys_id(cfg_phys_id), .cfg_log_id(cfg_log_id), .cfg_model(cfg_model),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_cmd(req_is_cmd),
    .msg_addr(msg_addr), .msg_data(msg_data), .cmd_word(cmd_word),
    .cmd_dest(cmd_dest), .cmd_src(cmd_src), .dlv_valid(dlv_valid),
    .arb_sync(arb_sync), .no_target(no_target), .dlv_mask(dlv_mask),
    .dlv_vector(dlv_vector), .dlv_mode(dlv_mode), .dlv_trig(dlv_trig)
  );

  task automatic check(input bit ok, input string tag, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  function automatic logic [N-1:0] exp_mask(input logic [7:0] dest, input logic lg,
      input logic [1:0] sh, input int src, input logic [2:0] mode);
    logic [N-1:0] m;
    bit found;
    m = '0;
    found = 0;
    case (sh)
      2'd0: begin
        if (!lg) begin
          if (dest == 8'hFF) m = '1;
          else
            for (int t = 0; t < N; t++)
              if (!found && b_phys[t] == dest) begin m[t] = 1'b1; found = 1; end
        end else begin
          for (int t = 0; t < N; t++) begin
            if (b_model[t] == 4'hF && (dest & b_log[t]) != 0) m[t] = 1'b1;
            if (b_model[t] == 4'h0 && dest[7:4] == b_log[t][7:4] &&
                (dest[3:0] & b_log[t][3:0]) != 0) m[t] = 1'b1;
          end
        end
      end
      2'd1: m[src] = 1'b1;
      2'd2: m = '1;
      default: begin m = '1; m[src] = 1'b0; end
    endcase
    if (mode == 3'd1) begin
      logic [N-1:0] k;
      k = '0;
      found = 0;
      for (int t = 0; t < N; t++)
        if (!found && m[t]) begin k[t] = 1'b1; found = 1; end
      m = k;
    end
    return m;
  endfunction

  task automatic cfg(input int i, input logic [7:0] p, input logic [7:0] l, input logic [3:0] md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(i); cfg_phys_id = p; cfg_log_id = l; cfg_model = md;
    b_phys[i] = p; b_log[i] = l; b_model[i] = md;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_req(input bit is_cmd, input logic [7:0] dest, input logic lg,
      input logic [7:0] vec, input logic [2:0] mode, input logic lvl, input logic trg,
      input logic [1:0] sh, input int src, input string tag);
    logic [N-1:0] em;
    bit e_arb, e_none, e_dlv, ok;
    em = exp_mask(dest, lg, is_cmd ? sh : 2'd0, src, mode);
    e_none = (em == '0);
    e_arb = !e_none && is_cmd && mode == 3'd5 && !lvl && trg;
    e_dlv = !e_none && !e_arb;
    req_is_cmd = is_cmd;
    msg_addr = {12'h000, dest, 9'h000, lg, 2'b00};
    msg_data = {16'h0000, trg, lvl, 3'b000, mode, vec};
    cmd_word = {12'h000, sh, 2'b00, trg, lvl, 2'b00, lg, mode, vec};
    cmd_dest = dest;
    cmd_src = IW'(src);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = (dlv_valid == e_dlv) && (arb_sync == e_arb) && (no_target == e_none) &&
         (dlv_mask == (e_none ? '0 : em)) && (dlv_vector == vec) &&
         (dlv_mode == mode) && (dlv_trig == trg);
    check(ok, tag, $sformatf("dest=%h sh=%0d src=%0d: got v/a/n=%b%b%b mask=%b vec=%h mode=%0d trig=%b exp %b%b%b mask=%b vec=%h mode=%0d trig=%b",
          dest, sh, src, dlv_valid, arb_sync, no_target, dlv_mask, dlv_vector, dlv_mode, dlv_trig,
          e_dlv, e_arb, e_none, em, vec, mode, trg));
    check(req_ready == 1'b0, "R10", $sformatf("ready after accept got %b exp 0", req_ready));
    @(negedge clk);
    check(req_ready == 1'b1 && !dlv_valid && !arb_sync && !no_target, "R10",
          $sformatf("idle got ready=%b strobes=%b%b%b exp 1 000", req_ready, dlv_valid, arb_sync, no_target));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin b_phys[i] = 8'(i); b_log[i] = 8'h00; b_model[i] = 4'hF; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(req_ready && !dlv_valid && !arb_sync && !no_target, "R11",
          $sformatf("reset got ready=%b strobes=%b%b%b exp 1 000", req_ready, dlv_valid, arb_sync, no_target));
    for (int d = 0; d <= N; d++)
      run_req(1, 8'(d), 0, 8'(d + 16), 3'd0, 1, 0, 2'd0, 0, "R11");

    // R12 program the table
    begin
      logic [7:0] lv [N];
      lv = '{8'h01, 8'h12, 8'h34, 8'h80, 8'h21, 8'h5A, 8'h44, 8'h18};
      for (int i = 0; i < N; i++)
        cfg(i, 8'((i * 37 + 5) & 8'hFF), lv[i], (i % 3 == 0) ? 4'hF : ((i % 3 == 1) ? 4'h0 : 4'h5));
      cfg(6, b_phys[2], lv[6], 4'h0);
    end

    // R3 R2 physical sweep via command
    for (int d = 0; d < 256; d++)
      run_req(1, 8'(d), 0, 8'(d), 3'd0, 1, d[0], 2'd0, 0, "R3");
    // R4 R5 R1 logical sweep via message
    for (int d = 0; d < 256; d++)
      run_req(0, 8'(d), 1, ~8'(d), (d[0] ? 3'd0 : 3'd4), 0, d[1], 2'd0, 0, "R4 R5 R1");
    // R1 message INIT with level 0 trigger 1 still delivers
    run_req(0, 8'hFF, 0, 8'h33, 3'd5, 0, 1, 2'd0, 0, "R1");
    // R6 shorthands
    for (int s = 1; s < 4; s++)
      for (int src = 0; src < N; src++)
        run_req(1, 8'h00, 0, 8'(s * 16 + src), 3'd0, 1, 0, 2'(s), src, "R6");
    // R7 lowest priority
    for (int d = 0; d < 256; d++)
      run_req(1, 8'(d), 1, 8'h40, 3'd1, 1, 0, 2'd0, 0, "R7");
    run_req(1, 8'h00, 0, 8'h41, 3'd1, 1, 0, 2'd2, 5, "R7");
    run_req(1, 8'h00, 0, 8'h42, 3'd1, 1, 0, 2'd3, 0, "R7");
    // R8 INIT handling
    run_req(1, 8'hFF, 0, 8'h00, 3'd5, 0, 1, 2'd0, 0, "R8");
    run_req(1, 8'hFF, 0, 8'h00, 3'd5, 1, 1, 2'd0, 0, "R8");
    run_req(1, 8'hFF, 0, 8'h00, 3'd5, 0, 0, 2'd0, 0, "R8");
    run_req(1, 8'h00, 0, 8'h00, 3'd5, 0, 1, 2'd3, 2, "R8");
    // R9 empty mask with INIT
    run_req(1, 8'hFE, 0, 8'h00, 3'd5, 0, 1, 2'd0, 0, "R9");
    // R12 rewrite then use
    cfg(3, 8'hC3, 8'h00, 4'h5);
    run_req(1, 8'hC3, 0, 8'h77, 3'd0, 1, 1, 2'd0, 0, "R12");
    done = 1;
    finish_run();
  end

endmodule